// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block gathers up to 32 interrupt sources and presents them to a processor as a single request line. Each source is fixed at elaboration as level-type or edge-type. A level-type source's status bit tracks the synchronized input. An edge-type source's status bit latches on a rising edge and stays set until software acknowledges it. The pending word is status masked by enable. A vector register gives the index of the lowest-numbered pending source, so source 0 has the highest priority.

Software uses a small synchronous register port with eight word-indexed registers. There are dedicated write-only strobes that set or clear enable bits without a read-modify-write, and a write-one-to-clear acknowledge. A two-bit master control gates both the output line and the capture of inputs into status.

Top module: `irq_ctrl`

## Requirements
- R1: After a synchronous reset, status, enable, master and the three strobe registers read 0, pending reads 0, vector reads all ones and `cpu_irq` is low.
- R2: `bus_addr` is a word index with this fixed map: 0 status, 1 pending, 2 enable, 3 acknowledge, 4 set-enable, 5 clear-enable, 6 vector, 7 master. A read strobe returns the addressed value on `bus_rdata` after the next clock edge.
- R3: Pending always reads status AND enable. Writes to index 1 and index 6 change no state.
- R4: Vector reads the index of the lowest-numbered set pending bit, and all ones when pending is zero.
- R5: A write to index 3 clears every status bit where the written word has a 1. Indices 3, 4 and 5 read back the last value written to them.
- R6: A write to index 4 ORs the word into enable. A write to index 5 clears the enable bits where the word has a 1. A write to index 2 loads enable directly.
- R7: `cpu_irq` is high exactly when master bit 0 and master bit 1 are both 1 and pending is nonzero.
- R8: While master bit 1 (capture) is 0, input changes do not alter status and `cpu_irq` is low.
- R9: With capture on, a level-type status bit equals its synchronized input, set while high and cleared while low.
- R10: With capture on, an edge-type status bit is set by a rising input edge. It stays set after the input falls and is cleared only by an acknowledge or a status write.
- R11: If an acknowledge of an edge-type bit commits on the same clock edge as a new rising edge of that source, the bit ends set.
- R12: A write to index 0 loads status with the word. With capture on, level-type bits are then re-taken from their inputs.
- R13: With the default two-stage synchronizer, an input change made between clock edges reaches status, and so `cpu_irq`, on the third following clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| src_i | input | NSRC | Raw interrupt source inputs |
| bus_addr | input | 3 | Word index of the register |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DW | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | DW | Read data, valid after the edge following the strobe |
| cpu_irq | output | 1 | Combined interrupt request |

## Verification
On every cycle the assertions check the following: acknowledge, set-enable and clear-enable take effect on the next edge; edge-type bits never drop without an acknowledge or status write; status freezes and the output stays low with capture off; and the vector always names the lowest pending bit. The bench scenarios are needed to show the synchronizer latency, level tracking against a changing input, the same-edge race between an acknowledge and a new edge, and read-back through the port of the strobe registers and of writes to the pending and vector indices.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
   localparam int REG_COUNT = 8;
   localparam int REG_AW    = $clog2(REG_COUNT);

   typedef enum logic [REG_AW-1:0] {
      OFS_STATUS = 3'd0,
      OFS_PEND   = 3'd1,
      OFS_ENABLE = 3'd2,
      OFS_ACK    = 3'd3,
      OFS_SETEN  = 3'd4,
      OFS_CLREN  = 3'd5,
      OFS_VECTOR = 3'd6,
      OFS_MASTER = 3'd7
   } reg_ofs_e;

   localparam int MST_OUT_BIT = 0;
   localparam int MST_CAP_BIT = 1;
endpackage

// File: rtl/irq_src_capture.sv
module irq_src_capture #(
   parameter int              NSRC        = 32,
   parameter logic [NSRC-1:0] EDGE_MASK   = '0,
   parameter int              SYNC_STAGES = 2
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [NSRC-1:0] src_i,
   output logic [NSRC-1:0] lvl_o,
   output logic [NSRC-1:0] rise_o
);
   for (genvar b = 0; b < NSRC; b++) begin : g_src
      logic [SYNC_STAGES-1:0] chain_q;
      always_ff @(posedge clk) begin
         if (rst) chain_q <= '0;
         else     chain_q <= {chain_q[SYNC_STAGES-2:0], src_i[b]};
      end
      if (EDGE_MASK[b]) begin : g_edge
         logic last_q;
         always_ff @(posedge clk) begin
            if (rst) last_q <= 1'b0;
            else     last_q <= chain_q[SYNC_STAGES-1];
         end
         assign rise_o[b] = chain_q[SYNC_STAGES-1] & ~last_q;
         assign lvl_o[b]  = 1'b0;
      end else begin : g_level
         assign rise_o[b] = 1'b0;
         assign lvl_o[b]  = chain_q[SYNC_STAGES-1];
      end
   end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
   parameter int NSRC = 32,
   parameter int DW   = 32
) (
   input  logic [NSRC-1:0] req_i,
   output logic [DW-1:0]   vec_o
);
   always_comb begin
      vec_o = '1;
      for (int i = NSRC - 1; i >= 0; i--) begin
         if (req_i[i]) vec_o = DW'(i);
      end
   end
endmodule

// File: rtl/irq_regfile.sv
module irq_regfile
   import irq_ctrl_pkg::*;
#(
   parameter int              NSRC      = 32,
   parameter int              DW        = 32,
   parameter logic [NSRC-1:0] EDGE_MASK = '0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [REG_AW-1:0] addr_i,
   input  logic              wr_i,
   input  logic [DW-1:0]     wdata_i,
   input  logic              rd_i,
   output logic [DW-1:0]     rdata_o,
   input  logic [NSRC-1:0]   lvl_i,
   input  logic [NSRC-1:0]   rise_i,
   input  logic [DW-1:0]     vector_i,
   output logic [NSRC-1:0]   status_o,
   output logic [NSRC-1:0]   enable_o,
   output logic [NSRC-1:0]   pending_o,
   output logic [DW-1:0]     master_o
);
   logic [NSRC-1:0] status_q, status_d, enable_q, enable_d, wbits;
   logic [DW-1:0]   master_q, ack_q, seten_q, clren_q;

   assign wbits = wdata_i[NSRC-1:0];

   always_comb begin
      status_d = status_q;
      if (wr_i && addr_i == OFS_STATUS) status_d = wbits;
      if (wr_i && addr_i == OFS_ACK)    status_d = status_d & ~wbits;
      if (master_q[MST_CAP_BIT])
         status_d = (status_d & EDGE_MASK) | (lvl_i & ~EDGE_MASK) | rise_i;
   end

   always_comb begin
      enable_d = enable_q;
      if (wr_i) begin
         case (addr_i)
            OFS_ENABLE: enable_d = wbits;
            OFS_SETEN:  enable_d = enable_q | wbits;
            OFS_CLREN:  enable_d = enable_q & ~wbits;
            default:    enable_d = enable_q;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         status_q <= '0;
         enable_q <= '0;
         master_q <= '0;
         ack_q    <= '0;
         seten_q  <= '0;
         clren_q  <= '0;
      end else begin
         status_q <= status_d;
         enable_q <= enable_d;
         if (wr_i && addr_i == OFS_MASTER) master_q <= wdata_i;
         if (wr_i && addr_i == OFS_ACK)    ack_q    <= wdata_i;
         if (wr_i && addr_i == OFS_SETEN)  seten_q  <= wdata_i;
         if (wr_i && addr_i == OFS_CLREN)  clren_q  <= wdata_i;
      end
   end

   assign pending_o = status_q & enable_q;
   assign status_o  = status_q;
   assign enable_o  = enable_q;
   assign master_o  = master_q;

   always_ff @(posedge clk) begin
      if (rst) rdata_o <= '0;
      else if (rd_i) begin
         case (addr_i)
            OFS_STATUS: rdata_o <= DW'(status_q);
            OFS_PEND:   rdata_o <= DW'(pending_o);
            OFS_ENABLE: rdata_o <= DW'(enable_q);
            OFS_ACK:    rdata_o <= ack_q;
            OFS_SETEN:  rdata_o <= seten_q;
            OFS_CLREN:  rdata_o <= clren_q;
            OFS_VECTOR: rdata_o <= vector_i;
            default:    rdata_o <= master_q;
         endcase
      end
   end
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
   import irq_ctrl_pkg::*;
#(
   parameter int              NSRC        = 32,
   parameter int              DW          = 32,
   parameter logic [NSRC-1:0] EDGE_MASK   = '0,
   parameter int              SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [NSRC-1:0]   src_i,
   input  logic [REG_AW-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [DW-1:0]     bus_wdata,
   input  logic              bus_rd,
   output logic [DW-1:0]     bus_rdata,
   output logic              cpu_irq
);
   if (NSRC < 2 || NSRC > DW) begin : g_bad_nsrc
      $error("irq_ctrl: NSRC must lie in 2..DW");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("irq_ctrl: SYNC_STAGES must be at least 2");
   end

   logic [NSRC-1:0] lvl, rise, status, enable, pending;
   logic [DW-1:0]   vector, master;

   irq_src_capture #(.NSRC(NSRC), .EDGE_MASK(EDGE_MASK), .SYNC_STAGES(SYNC_STAGES)) u_cap (
      .clk(clk), .rst(rst), .src_i(src_i), .lvl_o(lvl), .rise_o(rise));

   irq_prio_enc #(.NSRC(NSRC), .DW(DW)) u_enc (.req_i(pending), .vec_o(vector));

   irq_regfile #(.NSRC(NSRC), .DW(DW), .EDGE_MASK(EDGE_MASK)) u_regs (
      .clk(clk), .rst(rst), .addr_i(bus_addr), .wr_i(bus_wr), .wdata_i(bus_wdata),
      .rd_i(bus_rd), .rdata_o(bus_rdata), .lvl_i(lvl), .rise_i(rise),
      .vector_i(vector), .status_o(status), .enable_o(enable),
      .pending_o(pending), .master_o(master));

   assign cpu_irq = master[MST_OUT_BIT] & master[MST_CAP_BIT] & (|pending);
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk
   import irq_ctrl_pkg::*;
#(
   parameter int              NSRC      = 32,
   parameter int              DW        = 32,
   parameter logic [NSRC-1:0] EDGE_MASK = '0
) (
   input logic              clk,
   input logic              rst,
   input logic [REG_AW-1:0] bus_addr,
   input logic              bus_wr,
   input logic [DW-1:0]     bus_wdata,
   input logic              cpu_irq,
   input logic [NSRC-1:0]   status,
   input logic [NSRC-1:0]   enable,
   input logic [NSRC-1:0]   pending,
   input logic [NSRC-1:0]   rise,
   input logic [DW-1:0]     vector,
   input logic [DW-1:0]     master
);
   logic [NSRC-1:0] below, wb;
   logic            st_wr;
   always_comb begin
      below = '0;
      for (int i = 0; i < NSRC; i++) if (DW'(i) < vector) below[i] = 1'b1;
   end
   assign wb    = bus_wdata[NSRC-1:0];
   assign st_wr = bus_wr && (bus_addr == OFS_STATUS || bus_addr == OFS_ACK);

   p_ack_clears_r5: assert property (@(posedge clk) disable iff (rst)
      (bus_wr && bus_addr == OFS_ACK) |=>
      ((status & $past(wb) & EDGE_MASK & ~$past(rise)) == '0));
   p_seten_r6: assert property (@(posedge clk) disable iff (rst)
      (bus_wr && bus_addr == OFS_SETEN) |=> ((enable & $past(wb)) == $past(wb)));
   p_clren_r6: assert property (@(posedge clk) disable iff (rst)
      (bus_wr && bus_addr == OFS_CLREN) |=> ((enable & $past(wb)) == '0));
   p_vec_idle_r4: assert property (@(posedge clk) disable iff (rst)
      (pending == '0) |-> (vector == '1));
   p_vec_first_r4: assert property (@(posedge clk) disable iff (rst)
      (pending != '0) |-> (vector < DW'(NSRC) && ((pending >> vector) & NSRC'(1)) != '0
                           && (pending & below) == '0));
   p_irq_gate_r7: assert property (@(posedge clk) disable iff (rst)
      (bus_wr && bus_addr == OFS_MASTER && !bus_wdata[MST_OUT_BIT]) |=> !cpu_irq);
   p_cap_off_r8: assert property (@(posedge clk) disable iff (rst)
      (!master[MST_CAP_BIT] && !st_wr) |=> $stable(status));
   p_irq_low_r8: assert property (@(posedge clk) disable iff (rst)
      !master[MST_CAP_BIT] |-> !cpu_irq);
   p_edge_sticky_r10: assert property (@(posedge clk) disable iff (rst)
      !st_wr |=> (($past(status) & EDGE_MASK & ~status) == '0));
endmodule

bind irq_ctrl irq_ctrl_chk #(.NSRC(NSRC), .DW(DW), .EDGE_MASK(EDGE_MASK)) u_chk (
   .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
   .cpu_irq(cpu_irq), .status(status), .enable(enable), .pending(pending),
   .rise(rise), .vector(vector), .master(master));

// File: tb/irq_ctrl_test.sv
`timescale 1ns/1ps
module irq_ctrl_test;
   localparam logic [31:0] EDGES = 32'h0000_FF00;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] src_i = '0;
   logic [2:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic        bus_rd = 1'b0;
   logic [31:0] bus_rdata;
   logic        cpu_irq;

   int errors = 0, checks = 0;
   bit done = 1'b0;

   logic [31:0] m_st = '0, m_en = '0, m_mst = '0, m_ack = '0, m_set = '0, m_clr = '0;

   always #10 clk = ~clk;

   irq_ctrl #(.NSRC(32), .DW(32), .EDGE_MASK(EDGES), .SYNC_STAGES(2)) uut (
      .clk(clk), .rst(rst), .src_i(src_i), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .cpu_irq(cpu_irq));

   function automatic logic [31:0] exp_vec(logic [31:0] p);
      for (int i = 0; i < 32; i++) if (p[i]) return 32'(i);
      return '1;
   endfunction

   function automatic logic exp_irq();
      return m_mst[0] && m_mst[1] && ((m_st & m_en) != '0);
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic settle();
      if (m_mst[1]) m_st = (m_st & EDGES) | (src_i & ~EDGES);
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      @(negedge clk); bus_addr = a; bus_rd = 1'b1;
      @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk); bus_wr = 1'b0;
      @(negedge clk);
      case (a)
         3'd0: m_st = d;
         3'd2: m_en = d;
         3'd3: begin m_st = m_st & ~d; m_ack = d; end
         3'd4: begin m_en = m_en | d; m_set = d; end
         3'd5: begin m_en = m_en & ~d; m_clr = d; end
         3'd7: m_mst = d;
         default: ;
      endcase
      settle();
   endtask

   task automatic drive_src(input logic [31:0] v);
      @(negedge clk);
      if (m_mst[1]) m_st = m_st | (v & ~src_i & EDGES);
      src_i = v;
      repeat (4) @(negedge clk);
      settle();
   endtask

   task automatic check_all(string req);
      logic [31:0] d;
      rd(3'd0, d); check({req, " status"},  d, m_st);
      rd(3'd1, d); check({req, " pending"}, d, m_st & m_en);
      rd(3'd2, d); check({req, " enable"},  d, m_en);
      rd(3'd6, d); check({req, " vector"},  d, exp_vec(m_st & m_en));
      rd(3'd7, d); check({req, " master"},  d, m_mst);
      check({req, " cpu_irq"}, 32'(cpu_irq), 32'(exp_irq()));
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      void'($urandom(32'h1234_5678));
      repeat (3) @(negedge clk);
      rst = 1'b0;
      // R1: reset state, R2 map
      check("R1 cpu_irq", 32'(cpu_irq), 32'd0);
      check_all("R1 R2");
      rd(3'd3, d); check("R1 ack", d, 0);
      rd(3'd4, d); check("R1 seten", d, 0);
      rd(3'd5, d); check("R1 clren", d, 0);
      // R12: direct status write with capture off
      wr(3'd0, 32'hA5A5_5A03);
      check_all("R12");
      // R3: writes to pending / vector ignored
      wr(3'd2, 32'h0000_0F00);
      wr(3'd1, 32'hFFFF_FFFF);
      wr(3'd6, 32'h0000_0000);
      check_all("R3");
      // R6 / R5: set, clear, read-back
      wr(3'd4, 32'h8000_0001);
      wr(3'd5, 32'h0000_0300);
      check_all("R6");
      rd(3'd4, d); check("R5 seten readback", d, 32'h8000_0001);
      rd(3'd5, d); check("R5 clren readback", d, 32'h0000_0300);
      wr(3'd3, 32'h0000_0001);
      rd(3'd3, d); check("R5 ack readback", d, 32'h0000_0001);
      check_all("R5 R4");
      // R4: vector corners
      wr(3'd2, 32'hFFFF_FFFF);
      wr(3'd0, 32'h8000_0000);
      check_all("R4 top");
      wr(3'd0, 32'h0000_0000);
      check_all("R4 idle");
      // R7: master gating
      wr(3'd0, 32'h0000_0400);
      wr(3'd7, 32'h1);
      check_all("R7 out-only");
      wr(3'd7, 32'h3);
      check_all("R7 both");
      wr(3'd7, 32'h2);
      check_all("R7 cap-only");
      // R8: capture off holds status
      wr(3'd7, 32'h1);
      drive_src(32'h0000_0105);
      check_all("R8");
      // R9 / R10
      wr(3'd7, 32'h3);
      check_all("R9 resync");
      drive_src(32'h0000_0004);
      check_all("R9 R10 fall");
      wr(3'd3, 32'h0000_0500);
      check_all("R10 ack");
      // R13: latency of a level input to cpu_irq
      wr(3'd2, 32'h0000_0001);
      wr(3'd3, 32'hFFFF_FFFF);
      check("R13 pre", 32'(cpu_irq), 32'd0);
      @(negedge clk); src_i[0] = 1'b1;
      @(negedge clk); @(negedge clk);
      check("R13 two edges", 32'(cpu_irq), 32'd0);
      @(negedge clk);
      check("R13 three edges", 32'(cpu_irq), 32'd1);
      settle();
      // R11: acknowledge and new edge on the same edge
      drive_src(32'h0);
      wr(3'd3, 32'h0000_0100);
      @(negedge clk); src_i[8] = 1'b1;
      @(negedge clk);
      @(negedge clk); bus_addr = 3'd3; bus_wdata = 32'h0000_0100; bus_wr = 1'b1;
      @(negedge clk); bus_wr = 1'b0;
      m_ack = 32'h0000_0100;
      m_st = m_st | 32'h0000_0100;
      repeat (2) @(negedge clk);
      settle();
      rd(3'd0, d); check("R11 edge wins", d & 32'h0000_0100, 32'h0000_0100);
      check_all("R11");
      // random mix
      for (int n = 0; n < 300; n++) begin
         logic [31:0] v;
         v = $urandom();
         case ($urandom_range(0, 6))
            0: wr(3'd2, v);
            1: wr(3'd4, v);
            2: wr(3'd5, v);
            3: wr(3'd3, v);
            4: drive_src(v);
            5: wr(3'd7, ($urandom_range(0, 3) == 0) ? {30'd0, v[1:0]} : 32'h3);
            default: wr(3'd0, v);
         endcase
         check_all("R2 random");
      end
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule